// File: doc/BRIEF.md
# Path-Matched Trace Cache

This block stores short dynamic instruction traces so that the fetch stage can deliver several basic blocks in one access. Each stored trace is known by the address it starts at and by the directions its inner branches took when it was recorded. A lookup presents a fetch address and the predictor's directions for the next branches. One cycle later the block answers with an instruction vector, a count and the address fetch should use next. When no stored trace starts at the address, it raises a miss so that fetch continues from the ordinary instruction cache.

A lookup may agree with a stored trace only for its first few branches. The block then hands out the prefix that ends at the first branch whose prediction differs, and it names the address on the predicted side of that branch as the next fetch address. Two traces that begin at the same address but follow different paths can sit side by side in the two ways of a set.

A fill buffer watches the stream of retired instructions and assembles them into a new trace. It closes the trace when the trace reaches its instruction limit or its third branch, and it writes the trace into the cache at once.

Top module: `trace_cache`

## Requirements
- R1: While reset is held and during the first cycles after its release, every line is invalid and no response is reported. The first lookup after reset reports a miss.
- R2: A response (`rsp_valid_o` high) appears exactly one cycle after a lookup is accepted. In every other cycle `rsp_valid_o` is low.
- R3: When no valid line in the addressed set carries the lookup tag, the response has `rsp_miss_o`=1, `rsp_hit_o`=0 and `rsp_len_o`=0.
- R4: A full hit (`rsp_full_o`=1) occurs when the tag matches and every recorded inner branch flag equals its prediction bit. Bit j of `lk_pred_i` is the prediction for the j-th inner branch, and 1 means taken. The response length is the stored count. Slot i of `rsp_instr_o` (bits i*32 and up) holds the i-th instruction of the trace. The next address is the target of the last instruction if that instruction is a taken branch, and otherwise its address plus 4.
- R5: On a partial hit, the first recorded branch whose prediction differs sits at slot p. The response then has `rsp_full_o`=0, length p+1, and as next address the side of that branch the trace did not take (its target if it was recorded not taken, its address plus 4 if it was recorded taken). Slots at or beyond the length read as zero.
- R6: The fill buffer closes a trace on its 8th instruction or on its third branch, whichever comes first. It writes the trace in the clock edge that accepts that instruction, so a lookup issued afterwards sees it.
- R7: A trace's identity includes only the branches before its final instruction. A trace with no inner branch gives a full hit whatever the predictions are.
- R8: Two traces with the same start address but different recorded paths are held together in one set, and each one is returned for the predictions that follow its own path.
- R9: A full match is chosen over any partial match. Among partial matches, the longest prefix is chosen.
- R10: A fill whose start address, branch mask and masked flags equal those of a valid line overwrites that line. Otherwise the fill goes to the first invalid way, and if there is none, to the least recently used way. Both a lookup hit and a fill count as a use.
- R11: The set index is address bits [5:2] and the tag is bits [31:6]. A line whose tag differs in the same set gives a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid_i | input | 1 | Lookup request strobe |
| lk_addr_i | input | 32 | Fetch address of the lookup |
| lk_pred_i | input | 2 | Predicted directions of the next inner branches (1 = taken) |
| rsp_valid_o | output | 1 | Response present |
| rsp_hit_o | output | 1 | A trace or a prefix of one is supplied |
| rsp_full_o | output | 1 | The whole trace is supplied |
| rsp_miss_o | output | 1 | No trace; fetch from the instruction cache |
| rsp_len_o | output | 4 | Number of supplied instructions |
| rsp_next_o | output | 32 | Address to fetch after the supplied instructions |
| rsp_instr_o | output | 256 | Supplied instructions, slot 0 in the low bits |
| ret_valid_i | input | 1 | Retired instruction present |
| ret_pc_i | input | 32 | Address of the retired instruction |
| ret_instr_i | input | 32 | Retired instruction word |
| ret_branch_i | input | 1 | Retired instruction is a conditional branch |
| ret_taken_i | input | 1 | Branch outcome (1 = taken) |
| ret_target_i | input | 32 | Branch target address |

## Verification
The bench records three traces of different shape. The first closes on its third branch and mixes a taken and a not-taken inner branch. The second closes on its 8th instruction with one inner branch. The third has its only branch as its last instruction. Each start address is then looked up under all the prediction pairs that matter: agreeing pairs show full hits, disagreeing pairs tell a prefix cut at the first branch from one cut at the second, and the no-branch trace shows that predictions are ignored when nothing is recorded. Two traces with one start address then compete in the same set, which exercises full-over-partial and longest-prefix selection. A foreign tag, an eviction and an identical refill show which way the least-recently-used state and the duplicate check choose.

// File: rtl/tc_pkg.sv
package tc_pkg;
  parameter int AW    = 32;  // address width
  parameter int IW    = 32;  // instruction width
  parameter int NI    = 8;   // instructions per trace
  parameter int NB    = 3;   // basic blocks per trace
  parameter int SETS  = 16;
  parameter int WAYS  = 2;   // replacement state below assumes two ways

  localparam int NF   = NB - 1;                 // recorded inner branches
  localparam int CW   = $clog2(NI + 1);         // count width
  localparam int PW   = $clog2(NI);             // slot index width
  localparam int BCW  = $clog2(NF + 1);         // branch counter width
  localparam int IDXW = $clog2(SETS);
  localparam int OFFW = 2;                      // byte offset inside a word
  localparam int TAGW = AW - IDXW - OFFW;
  localparam int WSW  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int INC  = 1 << OFFW;

  typedef struct packed {
    logic [TAGW-1:0]         tag;
    logic [NF-1:0]           flg;   // recorded direction of each inner branch
    logic [NF-1:0]           msk;   // which inner branches exist
    logic [NF-1:0][PW-1:0]   pos;   // slot of each inner branch
    logic [NF-1:0][AW-1:0]   alt;   // address on the side not recorded
    logic [CW-1:0]           cnt;
    logic [AW-1:0]           nxt;   // address after the final instruction
    logic [NI-1:0][IW-1:0]   ins;
  } tc_line_t;

  typedef struct packed {
    logic          hit;
    logic          full;
    logic [CW-1:0] len;
    logic [AW-1:0] nxt;
  } tc_probe_t;
endpackage

// File: rtl/tc_way_match.sv
module tc_way_match
  import tc_pkg::*;
(
  input  logic            vld_i,
  input  tc_line_t        line_i,
  input  logic [TAGW-1:0] tag_i,
  input  logic [NF-1:0]   pred_i,
  output tc_probe_t       probe_o
);
  logic cut;

  always_comb begin
    probe_o = '0;
    cut     = 1'b0;
    if (vld_i && (line_i.tag == tag_i)) begin
      probe_o.hit  = 1'b1;
      probe_o.full = 1'b1;
      probe_o.len  = line_i.cnt;
      probe_o.nxt  = line_i.nxt;
      for (int j = 0; j < NF; j++) begin
        if (!cut && line_i.msk[j] && (line_i.flg[j] != pred_i[j])) begin
          cut          = 1'b1;
          probe_o.full = 1'b0;
          probe_o.len  = CW'(line_i.pos[j]) + CW'(1);
          probe_o.nxt  = line_i.alt[j];
        end
      end
    end
  end
endmodule

// File: rtl/tc_pick.sv
module tc_pick
  import tc_pkg::*;
(
  input  tc_probe_t        probe_i [WAYS],
  output tc_probe_t        best_o,
  output logic [WSW-1:0]   sel_o
);
  always_comb begin
    best_o = '0;
    sel_o  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (probe_i[w].hit &&
          (!best_o.hit ||
           (probe_i[w].full && !best_o.full) ||
           ((probe_i[w].full == best_o.full) && (probe_i[w].len > best_o.len)))) begin
        best_o = probe_i[w];
        sel_o  = WSW'(w);
      end
    end
  end
endmodule

// File: rtl/tc_fill.sv
module tc_fill
  import tc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            ret_valid_i,
  input  logic [AW-1:0]   ret_pc_i,
  input  logic [IW-1:0]   ret_instr_i,
  input  logic            ret_branch_i,
  input  logic            ret_taken_i,
  input  logic [AW-1:0]   ret_target_i,
  output logic            wr_en_o,
  output logic [IDXW-1:0] wr_idx_o,
  output tc_line_t        wr_line_o
);
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [BCW-1:0] bcnt_q, bcnt_d;
  logic [AW-1:0]  start_q, start_d;
  tc_line_t       line_q, line_d;
  logic           first, last, inner;
  logic [AW-1:0]  seq_pc;

  always_comb begin
    first   = (cnt_q == '0);
    start_d = first ? ret_pc_i : start_q;
    last    = (cnt_q == CW'(NI - 1)) || (ret_branch_i && (bcnt_q == BCW'(NF)));
    inner   = ret_branch_i && !last;
    seq_pc  = ret_pc_i + AW'(INC);

    line_d = line_q;
    if (first) begin
      line_d.msk = '0;
      line_d.flg = '0;
    end
    line_d.tag = start_d[AW-1 -: TAGW];
    line_d.ins[cnt_q[PW-1:0]] = ret_instr_i;
    line_d.cnt = cnt_q + CW'(1);
    line_d.nxt = (ret_branch_i && ret_taken_i) ? ret_target_i : seq_pc;
    for (int j = 0; j < NF; j++) begin
      if (inner && (bcnt_q == BCW'(j))) begin
        line_d.msk[j] = 1'b1;
        line_d.flg[j] = ret_taken_i;
        line_d.pos[j] = cnt_q[PW-1:0];
        line_d.alt[j] = ret_taken_i ? seq_pc : ret_target_i;
      end
    end

    cnt_d  = cnt_q;
    bcnt_d = bcnt_q;
    if (ret_valid_i) begin
      if (last) begin
        cnt_d  = '0;
        bcnt_d = '0;
      end else begin
        cnt_d  = cnt_q + CW'(1);
        bcnt_d = bcnt_q + BCW'(inner);
      end
    end
  end

  assign wr_en_o   = ret_valid_i && last;
  assign wr_idx_o  = start_d[OFFW +: IDXW];
  assign wr_line_o = line_d;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bcnt_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      bcnt_q <= bcnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ret_valid_i) begin
      line_q  <= line_d;
      start_q <= start_d;
    end
  end

  AST_FILL_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q < CW'(NI)) else $error("fill slot overflow"); // R6
  AST_FILL_BRANCH_BOUND: assert property (@(posedge clk) disable iff (!rst_ni)
    bcnt_q <= BCW'(NF)) else $error("fill branch overflow"); // R6
  AST_FILL_RESTART: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_en_o |=> (cnt_q == '0) && (bcnt_q == '0)) else $error("fill did not restart"); // R6
endmodule

// File: rtl/trace_cache.sv
module trace_cache
  import tc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid_i,
  input  logic [AW-1:0]     lk_addr_i,
  input  logic [NF-1:0]     lk_pred_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_full_o,
  output logic              rsp_miss_o,
  output logic [CW-1:0]     rsp_len_o,
  output logic [AW-1:0]     rsp_next_o,
  output logic [NI*IW-1:0]  rsp_instr_o,
  input  logic              ret_valid_i,
  input  logic [AW-1:0]     ret_pc_i,
  input  logic [IW-1:0]     ret_instr_i,
  input  logic              ret_branch_i,
  input  logic              ret_taken_i,
  input  logic [AW-1:0]     ret_target_i
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // storage
  tc_line_t        line_q [SETS][WAYS];
  logic [WAYS-1:0] vld_q  [SETS];
  logic [SETS-1:0] lru_q, lru_d;     // way to evict next in each set

  // lookup path
  logic [IDXW-1:0] lk_idx;
  logic [TAGW-1:0] lk_tag;
  tc_probe_t       probe [WAYS];
  tc_probe_t       best;
  logic [WSW-1:0]  sel;
  logic            unused_lo;

  assign lk_idx    = lk_addr_i[OFFW +: IDXW];
  assign lk_tag    = lk_addr_i[AW-1 -: TAGW];
  assign unused_lo = ^lk_addr_i[OFFW-1:0];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    tc_way_match u_match (
      .vld_i   (vld_q[lk_idx][w]),
      .line_i  (line_q[lk_idx][w]),
      .tag_i   (lk_tag),
      .pred_i  (lk_pred_i),
      .probe_o (probe[w])
    );

    AST_FULL_WINS: assert property (@(posedge clk) disable iff (!rst_ni)
      (lk_valid_i && probe[w].full) |=> rsp_full_o) else $error("full match lost"); // R9
    AST_LONGEST_PREFIX: assert property (@(posedge clk) disable iff (!rst_ni)
      (lk_valid_i && probe[w].hit && (probe[w].full == best.full)) |-> (best.len >= probe[w].len))
      else $error("shorter prefix chosen"); // R9
  end

  tc_pick u_pick (
    .probe_i (probe),
    .best_o  (best),
    .sel_o   (sel)
  );

  // fill path
  logic            wr_en;
  logic [IDXW-1:0] wr_idx;
  tc_line_t        wr_line;
  logic [WSW-1:0]  fill_way;
  logic            got_inv, got_dup;

  tc_fill u_fill (
    .clk          (clk),
    .rst_ni       (rst_ni),
    .ret_valid_i  (ret_valid_i),
    .ret_pc_i     (ret_pc_i),
    .ret_instr_i  (ret_instr_i),
    .ret_branch_i (ret_branch_i),
    .ret_taken_i  (ret_taken_i),
    .ret_target_i (ret_target_i),
    .wr_en_o      (wr_en),
    .wr_idx_o     (wr_idx),
    .wr_line_o    (wr_line)
  );

  always_comb begin
    fill_way = WSW'(lru_q[wr_idx]);
    got_inv  = 1'b0;
    got_dup  = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!got_inv && !vld_q[wr_idx][w]) begin
        got_inv  = 1'b1;
        fill_way = WSW'(w);
      end
    end
    for (int w = 0; w < WAYS; w++) begin
      if (!got_dup && vld_q[wr_idx][w] &&
          (line_q[wr_idx][w].tag == wr_line.tag) &&
          (line_q[wr_idx][w].msk == wr_line.msk) &&
          (((line_q[wr_idx][w].flg ^ wr_line.flg) & wr_line.msk) == '0)) begin
        got_dup  = 1'b1;
        fill_way = WSW'(w);
      end
    end
  end

  // replacement state next value: a fill overrides a lookup use in the same set
  always_comb begin
    lru_d = lru_q;
    if (lk_valid_i && best.hit) lru_d[lk_idx] = ~sel[0];
    if (wr_en)                  lru_d[wr_idx] = ~fill_way[0];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      lru_q <= '0;
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else begin
      lru_q <= lru_d;
      if (wr_en) vld_q[wr_idx][fill_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) line_q[wr_idx][fill_way] <= wr_line;
  end

  // response
  logic [NI*IW-1:0] rsp_instr_d;

  always_comb begin
    for (int i = 0; i < NI; i++) begin
      rsp_instr_d[i*IW +: IW] = (CW'(i) < best.len) ? line_q[lk_idx][sel].ins[i] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_full_o  <= 1'b0;
      rsp_miss_o  <= 1'b0;
      rsp_len_o   <= '0;
    end else begin
      rsp_valid_o <= lk_valid_i;
      if (lk_valid_i) begin
        rsp_hit_o  <= best.hit;
        rsp_full_o <= best.full;
        rsp_miss_o <= !best.hit;
        rsp_len_o  <= best.len;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (lk_valid_i) begin
      rsp_next_o  <= best.nxt;
      rsp_instr_o <= rsp_instr_d;
    end
  end

  // checker state
  logic [IDXW-1:0] chk_idx_q;
  logic [WSW-1:0]  chk_way_q;
  always_ff @(posedge clk) begin
    chk_idx_q <= wr_idx;
    chk_way_q <= fill_way;
  end

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_ni)
    lk_valid_i |=> rsp_valid_o) else $error("response missing"); // R2
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_ni)
    !lk_valid_i |=> !rsp_valid_o) else $error("spurious response"); // R2
  AST_MISS_EMPTY: assert property (@(posedge clk) disable iff (!rst_ni)
    (rsp_valid_o && rsp_miss_o) |-> (rsp_len_o == '0) && !rsp_hit_o) else $error("miss with data"); // R3
  AST_HIT_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_ni)
    (rsp_valid_o && rsp_hit_o) |-> (rsp_len_o != '0) && (rsp_len_o <= CW'(NI)))
    else $error("hit length out of range"); // R4
  AST_FILL_MAKES_VALID: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_en |=> vld_q[chk_idx_q][chk_way_q]) else $error("filled line not valid"); // R6
  AST_LRU_AWAY_FROM_FILL: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_en |=> (lru_q[chk_idx_q] != chk_way_q[0])) else $error("fill way left as victim"); // R10
endmodule

// File: tb/test_trace_cache.sv
module test_trace_cache;
  import tc_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              lk_valid_i;
  logic [AW-1:0]     lk_addr_i;
  logic [NF-1:0]     lk_pred_i;
  logic              rsp_valid_o, rsp_hit_o, rsp_full_o, rsp_miss_o;
  logic [CW-1:0]     rsp_len_o;
  logic [AW-1:0]     rsp_next_o;
  logic [NI*IW-1:0]  rsp_instr_o;
  logic              ret_valid_i;
  logic [AW-1:0]     ret_pc_i;
  logic [IW-1:0]     ret_instr_i;
  logic              ret_branch_i, ret_taken_i;
  logic [AW-1:0]     ret_target_i;

  always #4 clk = ~clk;  // 125 MHz

  trace_cache i_trace_cache (
    .clk(clk), .rst_n(rst_n),
    .lk_valid_i(lk_valid_i), .lk_addr_i(lk_addr_i), .lk_pred_i(lk_pred_i),
    .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_full_o(rsp_full_o),
    .rsp_miss_o(rsp_miss_o), .rsp_len_o(rsp_len_o), .rsp_next_o(rsp_next_o),
    .rsp_instr_o(rsp_instr_o),
    .ret_valid_i(ret_valid_i), .ret_pc_i(ret_pc_i), .ret_instr_i(ret_instr_i),
    .ret_branch_i(ret_branch_i), .ret_taken_i(ret_taken_i), .ret_target_i(ret_target_i)
  );

  typedef struct {
    string            req;
    logic             miss;
    logic             full;
    logic [CW-1:0]    len;
    logic [AW-1:0]    nxt;
    logic [NI*IW-1:0] ins;
  } exp_t;

  exp_t q[$];
  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  localparam logic [31:0] K1 = 32'h5500_0000;
  localparam logic [31:0] K2 = 32'h6600_0000;

  function automatic void check(input bit ok, input string req, input string what,
                                input logic [NI*IW-1:0] act, input logic [NI*IW-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endfunction

  // expected instruction vector built from slot addresses
  function automatic logic [NI*IW-1:0] pk(input logic [31:0] a0, a1, a2, a3, a4, a5, a6, a7,
                                          input int n, input logic [31:0] k);
    logic [31:0] a [NI];
    logic [NI*IW-1:0] v;
    a[0]=a0; a[1]=a1; a[2]=a2; a[3]=a3; a[4]=a4; a[5]=a5; a[6]=a6; a[7]=a7;
    v = '0;
    for (int i = 0; i < NI; i++) if (i < n) v[i*IW +: IW] = a[i] + k;
    return v;
  endfunction

  // monitor: pops expectations as responses arrive
  always @(negedge clk) begin
    if (rst_n && rsp_valid_o) begin
      if (q.size() == 0) begin
        check(1'b0, "R2", "response without lookup", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(rsp_miss_o == e.miss,  e.req, "miss", rsp_miss_o, e.miss);
        check(rsp_hit_o  == !e.miss, e.req, "hit",  rsp_hit_o, !e.miss);
        check(rsp_len_o  == e.len,   e.req, "len",  rsp_len_o, e.len);
        if (!e.miss) begin
          check(rsp_full_o  == e.full, e.req, "full", rsp_full_o, e.full);
          check(rsp_next_o  == e.nxt,  e.req, "next", rsp_next_o, e.nxt);
          check(rsp_instr_o == e.ins,  e.req, "instr", rsp_instr_o, e.ins);
        end
      end
    end
  end

  // driver: pushes the expectation, then issues the lookup for one cycle
  task automatic lookup(input string req, input logic [31:0] addr, input logic [1:0] pred,
                        input logic miss, input logic full, input int len,
                        input logic [31:0] nxt, input logic [NI*IW-1:0] ins);
    exp_t e;
    e.req = req; e.miss = miss; e.full = full; e.len = CW'(len); e.nxt = nxt; e.ins = ins;
    q.push_back(e);
    @(negedge clk);
    lk_valid_i = 1'b1; lk_addr_i = addr; lk_pred_i = pred;
    @(negedge clk);
    lk_valid_i = 1'b0;
  endtask

  task automatic retire(input logic [31:0] pc, input logic [31:0] k, input logic br,
                        input logic tkn, input logic [31:0] tgt);
    @(negedge clk);
    ret_valid_i = 1'b1; ret_pc_i = pc; ret_instr_i = pc + k;
    ret_branch_i = br; ret_taken_i = tkn; ret_target_i = tgt;
    @(negedge clk);
    ret_valid_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    finish_run();
  end

  localparam logic [31:0] A = 32'h0000_1010;  // set 4
  localparam logic [31:0] E = 32'h0000_1410;  // set 4, other tag
  localparam logic [31:0] D = 32'h0000_5000;  // set 0

  initial begin
    rst_n = 1'b0; lk_valid_i = 0; lk_addr_i = 0; lk_pred_i = 0;
    ret_valid_i = 0; ret_pc_i = 0; ret_instr_i = 0; ret_branch_i = 0; ret_taken_i = 0; ret_target_i = 0;
    repeat (4) @(negedge clk);
    check(!rsp_valid_o && !rsp_hit_o && !rsp_miss_o, "R1", "outputs in reset",
          {rsp_valid_o, rsp_hit_o, rsp_miss_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!rsp_valid_o, "R2", "idle valid", rsp_valid_o, 0);

    lookup("R1", A, 2'b01, 1, 0, 0, 0, '0);

    // trace 1: closes on its third branch
    retire(A,            K1, 0, 0, 0);
    retire(A + 4,        K1, 1, 1, 32'h2000);
    retire(32'h2000,     K1, 0, 0, 0);
    retire(32'h2004,     K1, 1, 0, 32'h3000);
    retire(32'h2008,     K1, 0, 0, 0);
    retire(32'h200C,     K1, 1, 1, 32'h4000);

    lookup("R4", A, 2'b01, 0, 1, 6, 32'h4000,
           pk(A, A+4, 32'h2000, 32'h2004, 32'h2008, 32'h200C, 0, 0, 6, K1));
    lookup("R5", A, 2'b11, 0, 0, 4, 32'h3000,
           pk(A, A+4, 32'h2000, 32'h2004, 0, 0, 0, 0, 4, K1));
    lookup("R5", A, 2'b00, 0, 0, 2, A + 8,
           pk(A, A+4, 0, 0, 0, 0, 0, 0, 2, K1));

    // trace 2: same start, other path, closes at 8 instructions
    retire(A, K1, 0, 0, 0);
    retire(A + 4, K1, 1, 0, 32'h2000);
    for (int i = 2; i < 8; i++) retire(A + 4*i, K1, 0, 0, 0);

    lookup("R8", A, 2'b00, 0, 1, 8, A + 32'h20,
           pk(A, A+4, A+8, A+12, A+16, A+20, A+24, A+28, 8, K1));
    lookup("R8", A, 2'b01, 0, 1, 6, 32'h4000,
           pk(A, A+4, 32'h2000, 32'h2004, 32'h2008, 32'h200C, 0, 0, 6, K1));
    lookup("R9", A, 2'b11, 0, 0, 4, 32'h3000,
           pk(A, A+4, 32'h2000, 32'h2004, 0, 0, 0, 0, 4, K1));
    lookup("R9", A, 2'b10, 0, 1, 8, A + 32'h20,
           pk(A, A+4, A+8, A+12, A+16, A+20, A+24, A+28, 8, K1));
    lookup("R11", E, 2'b00, 1, 0, 0, 0, '0);

    // trace 3: only branch is the final instruction
    for (int i = 0; i < 7; i++) retire(D + 4*i, K1, 0, 0, 0);
    retire(D + 28, K1, 1, 1, 32'h6000);
    lookup("R7", D, 2'b11, 0, 1, 8, 32'h6000,
           pk(D, D+4, D+8, D+12, D+16, D+20, D+24, D+28, 8, K1));
    lookup("R7", D, 2'b00, 0, 1, 8, 32'h6000,
           pk(D, D+4, D+8, D+12, D+16, D+20, D+24, D+28, 8, K1));

    // trace 4 in set 4 evicts the least recently used way (trace 1)
    retire(E,     K1, 1, 0, 32'h7000);
    retire(E + 4, K1, 1, 0, 32'h7100);
    retire(E + 8, K1, 1, 1, 32'h7200);
    lookup("R10", A, 2'b01, 0, 0, 2, 32'h2000,
           pk(A, A+4, 0, 0, 0, 0, 0, 0, 2, K1));
    lookup("R10", E, 2'b00, 0, 1, 3, 32'h7200,
           pk(E, E+4, E+8, 0, 0, 0, 0, 0, 3, K1));
    lookup("R10", A, 2'b00, 0, 1, 8, A + 32'h20,
           pk(A, A+4, A+8, A+12, A+16, A+20, A+24, A+28, 8, K1));

    // identical refill of trace 2 with new words overwrites in place
    retire(A, K2, 0, 0, 0);
    retire(A + 4, K2, 1, 0, 32'h2000);
    for (int i = 2; i < 8; i++) retire(A + 4*i, K2, 0, 0, 0);
    lookup("R10", E, 2'b00, 0, 1, 3, 32'h7200,
           pk(E, E+4, E+8, 0, 0, 0, 0, 0, 3, K1));
    lookup("R10", A, 2'b00, 0, 1, 8, A + 32'h20,
           pk(A, A+4, A+8, A+12, A+16, A+20, A+24, A+28, 8, K2));

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R2", "pending responses", q.size(), 0);
    finish_run();
  end
endmodule